// File: doc/BRIEF.md
# Mode-Configurable Wrapping Address Pointer Bank

This block holds a small set of address pointers into a 128-word local memory. Each pointer owns a mode register that sets two things: how the pointer steps when the memory is accessed through it, and which of its bits may change when it steps. With one mechanism, software can use a pointer as a plain indexed variable slot, a block copier, a stack that grows up or down, or a circular buffer whose depth is a power of two.

For each pointer, the block takes a mode write, a direct pointer write, and a read strobe and a write strobe. Each cycle it returns the effective memory address for the access in progress, which is combinational from the current state and the strobes. The registered pointer takes the stepped value on the next clock edge. The memory array and any occupancy tracking sit outside this block.

Top module: `wptr_bank`

## Requirements
- R1: After reset every pointer holds 0 and every mode register holds step code 00 with an all-ones change mask.
- R2: With step code 00, neither a read nor a write changes the pointer, and the effective address equals the pointer.
- R3: With step code 01, reads and writes both use the current pointer as the address and then increment it.
- R4: With step code 10, a read increments first and uses the incremented value as the address, and a write uses the current pointer and then decrements it (a stack growing downward).
- R5: With step code 11, a read decrements first and uses the decremented value as the address, and a write uses the current pointer and then increments it (a stack growing upward).
- R6: A stepped pointer equals (old AND NOT mask) OR ((old ± 1) AND mask). Pointer bits whose mask bit is 0 never change on a step. For example, mask 0001111 wraps the pointer inside an aligned 16-word window.
- R7: The pointer register takes the stepped value after every stepping access. The effective address is the stepped value for pre-step accesses and the old value for post-step accesses and for cycles with no access.
- R8: A direct pointer write loads the written value at the next edge and overrides any step requested in the same cycle.
- R9: Each pointer has its own mode register, loaded only by its own mode-write strobe. Writing one pointer's mode does not affect any other pointer.
- R10: When the read and write strobes of a pointer are both high in one cycle, the access is treated as a write and the read strobe is ignored.
- R11: A mode write takes effect from the next cycle. An access in the same cycle as the mode write uses the previous mode. The mode word holds the step code in bits [1:0] and the change mask in bits [8:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | NPTR | Per-pointer mode-write strobe |
| mode_wdata | input | AW+2 | Mode word: step code [1:0], change mask [AW+1:2] |
| ptr_we | input | NPTR | Per-pointer direct pointer-write strobe |
| ptr_wdata | input | AW | Value loaded by a pointer write |
| rd_stb | input | NPTR | Per-pointer read access strobe |
| wr_stb | input | NPTR | Per-pointer write access strobe |
| acc_addr | output | NPTR*AW | Effective address for each pointer's current access |
| ptr_value | output | NPTR*AW | Registered value of each pointer |

## Verification
The hardest cases to reach are steps that cross the edge of a partial mask window, where the bits outside the mask must stay fixed. Examples are an increment from the top of a 16-word window and a decrement from its bottom. The stimulus reaches them by loading a pointer directly to the window edge, then stepping it with a read in one direction and a write in the other. A long random phase then mixes mode writes, pointer writes and accesses in the same cycle across both pointers. A behavioural model checks the address and the pointer on every cycle.

// File: rtl/wptr_pkg.sv
package wptr_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD    = 2'b00,
        STEP_POST_UP = 2'b01,
        STEP_DN_STK  = 2'b10,
        STEP_UP_STK  = 2'b11
    } step_mode_e;
endpackage

// File: rtl/wptr_mode_reg.sv
module wptr_mode_reg
    import wptr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW+1:0] wdata,
    output step_mode_e    step_mode,
    output logic [AW-1:0] mask
);
    typedef struct packed {
        logic [AW-1:0] mask;
        step_mode_e    step;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d.step = step_mode_e'(wdata[1:0]);
            mode_d.mask = wdata[AW+1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.step <= STEP_HOLD;
            mode_q.mask <= '1;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign step_mode = mode_q.step;
    assign mask      = mode_q.mask;

    // R11: a mode write is visible from the following cycle
    assert_mode_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ({mask, step_mode} == $past(wdata)));
endmodule

// File: rtl/wptr_step.sv
module wptr_step
    import wptr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mask,
    input  step_mode_e    step_mode,
    input  logic          rd,
    input  logic          wr,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] stepped,
    output logic          moves,
    output logic          pre
);
    logic          up;
    logic [AW-1:0] raw;

    always_comb begin
        up    = 1'b1;
        pre   = 1'b0;
        moves = rd | wr;
        unique case (step_mode)
            STEP_HOLD:    moves = 1'b0;
            STEP_POST_UP: up = 1'b1;
            STEP_DN_STK: begin
                up  = !wr;
                pre = !wr && rd;
            end
            STEP_UP_STK: begin
                up  = wr;
                pre = !wr && rd;
            end
            default:      moves = 1'b0;
        endcase
        raw      = up ? ptr + AW'(1) : ptr - AW'(1);
        stepped  = (ptr & ~mask) | (raw & mask);
        eff_addr = pre ? stepped : ptr;
    end
endmodule

// File: rtl/wptr_unit.sv
module wptr_unit
    import wptr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic [AW+1:0] mode_wdata,
    input  logic          ptr_we,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          rd_stb,
    input  logic          wr_stb,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] ptr_value
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t    st_d, st_q;
    step_mode_e    step_mode;
    logic [AW-1:0] mask;
    logic [AW-1:0] stepped;
    logic          moves;
    logic          pre;

    wptr_mode_reg #(.AW(AW)) i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mode_we),
        .wdata     (mode_wdata),
        .step_mode (step_mode),
        .mask      (mask)
    );

    wptr_step #(.AW(AW)) i_step (
        .ptr       (st_q.ptr),
        .mask      (mask),
        .step_mode (step_mode),
        .rd        (rd_stb),
        .wr        (wr_stb),
        .eff_addr  (acc_addr),
        .stepped   (stepped),
        .moves     (moves),
        .pre       (pre)
    );

    always_comb begin
        st_d = st_q;
        if (ptr_we) begin
            st_d.ptr = ptr_wdata;
        end else if (moves) begin
            st_d.ptr = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_value = st_q.ptr;

    // R2: hold mode never moves the pointer
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && step_mode == STEP_HOLD && !ptr_we) |=> $stable(ptr_value));

    // R6: bits outside the mask never change unless loaded directly
    assert_mask_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> (((ptr_value ^ $past(ptr_value)) & ~$past(mask)) == '0));

    // R8: a direct write wins over any step
    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (ptr_value == $past(ptr_wdata)));

    // R7: pre-step access address becomes the new pointer
    assert_pre_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && pre && !ptr_we) |=> (ptr_value == $past(acc_addr)));

    // R7: otherwise the access uses the current pointer
    assert_post_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pre |-> (acc_addr == ptr_value));
endmodule

// File: rtl/wptr_bank.sv
module wptr_bank #(
    parameter  int DEPTH = 128,
    parameter  int NPTR  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int MW    = AW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPTR-1:0]    mode_we,
    input  logic [MW-1:0]      mode_wdata,
    input  logic [NPTR-1:0]    ptr_we,
    input  logic [AW-1:0]      ptr_wdata,
    input  logic [NPTR-1:0]    rd_stb,
    input  logic [NPTR-1:0]    wr_stb,
    output logic [NPTR*AW-1:0] acc_addr,
    output logic [NPTR*AW-1:0] ptr_value
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        wptr_unit #(.AW(AW)) i_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_we    (mode_we[g]),
            .mode_wdata (mode_wdata),
            .ptr_we     (ptr_we[g]),
            .ptr_wdata  (ptr_wdata),
            .rd_stb     (rd_stb[g]),
            .wr_stb     (wr_stb[g]),
            .acc_addr   (acc_addr[g*AW +: AW]),
            .ptr_value  (ptr_value[g*AW +: AW])
        );
    end
endmodule

// File: tb/test_wptr_bank.sv
module test_wptr_bank;
    localparam int NP = 2;
    localparam int AW = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    mode_we = '0;
    logic [AW+1:0]    mode_wdata = '0;
    logic [NP-1:0]    ptr_we = '0;
    logic [AW-1:0]    ptr_wdata = '0;
    logic [NP-1:0]    rd_stb = '0;
    logic [NP-1:0]    wr_stb = '0;
    logic [NP*AW-1:0] acc_addr;
    logic [NP*AW-1:0] ptr_value;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int m_ptr[NP];
    int m_step[NP];
    int m_mask[NP];

    always #5 clk = ~clk;

    wptr_bank #(.DEPTH(128), .NPTR(NP)) i_wptr_bank (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .acc_addr(acc_addr), .ptr_value(ptr_value)
    );

    function automatic int stepv(int p, int k, bit up);
        int n = up ? p + 1 : p + 127;
        return ((p & ~k) | (n & k)) & 127;
    endfunction

    function automatic int mk(int mask, int step);
        return ((mask & 127) << 2) | (step & 3);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, int mwe, int mdat, int pwe, int pdat, int rd, int wr);
        int nxt[NP];
        mode_we = NP'(mwe); mode_wdata = (AW+2)'(mdat);
        ptr_we = NP'(pwe); ptr_wdata = AW'(pdat);
        rd_stb = NP'(rd); wr_stb = NP'(wr);
        #1;
        for (int i = 0; i < NP; i++) begin
            bit acc = rd[i] | wr[i];
            bit w = wr[i];
            bit up = 1'b1;
            bit pre = 1'b0;
            bit mv = acc;
            int st, ea;
            case (m_step[i])
                0: mv = 1'b0;
                1: up = 1'b1;
                2: begin up = !w; pre = !w && acc; end
                default: begin up = w; pre = !w && acc; end
            endcase
            st = stepv(m_ptr[i], m_mask[i], up);
            ea = pre ? st : m_ptr[i];
            chk(tag, $sformatf("acc_addr[%0d]", i), int'(acc_addr[i*AW +: AW]), ea);
            chk(tag, $sformatf("ptr_value[%0d]", i), int'(ptr_value[i*AW +: AW]), m_ptr[i]);
            nxt[i] = pwe[i] ? (pdat & 127) : (mv ? st : m_ptr[i]);
        end
        @(posedge clk);
        for (int i = 0; i < NP; i++) begin
            m_ptr[i] = nxt[i];
            if (mwe[i]) begin
                m_step[i] = mdat & 3;
                m_mask[i] = (mdat >> 2) & 127;
            end
        end
        @(negedge clk);
        mode_we = '0; ptr_we = '0; rd_stb = '0; wr_stb = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin m_ptr[i] = 0; m_step[i] = 0; m_mask[i] = 127; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, and default mode holds on access (R2)
        cyc("R1", 0, 0, 0, 0, 0, 0);
        cyc("R1", 0, 0, 0, 0, 3, 0);
        cyc("R2", 0, 0, 0, 0, 0, 3);
        // R8: direct load, then R2 hold with a nonzero pointer
        cyc("R8", 0, 0, 1, 45, 0, 0);
        cyc("R2", 0, 0, 0, 0, 1, 1);
        cyc("R2", 0, 0, 0, 0, 1, 0);
        // R3: post increment, full mask wrap 127 -> 0
        cyc("R3", 1, mk(127, 1), 1, 126, 0, 0);
        cyc("R3", 0, 0, 0, 0, 1, 0);
        cyc("R3", 0, 0, 0, 0, 0, 1);
        cyc("R3", 0, 0, 0, 0, 1, 0);
        // R4: downward stack
        cyc("R4", 1, mk(127, 2), 1, 10, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1);
        cyc("R4", 0, 0, 0, 0, 0, 1);
        cyc("R4", 0, 0, 0, 0, 1, 0);
        cyc("R4", 0, 0, 0, 0, 1, 0);
        // R5: upward stack, wrap 0 -> 127 on pre-decrement
        cyc("R5", 1, mk(127, 3), 1, 1, 0, 0);
        cyc("R5", 0, 0, 0, 0, 1, 0);
        cyc("R5", 0, 0, 0, 0, 1, 0);
        cyc("R5", 0, 0, 0, 0, 0, 1);
        cyc("R5", 0, 0, 0, 0, 0, 1);
        // R6: 16-word window at 0x20..0x2F
        cyc("R6", 1, mk(15, 1), 1, 47, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 1);
        cyc("R6", 0, 0, 0, 0, 1, 0);
        cyc("R6", 1, mk(15, 3), 1, 32, 0, 0);
        cyc("R6", 0, 0, 0, 0, 1, 0);
        cyc("R6", 0, 0, 0, 0, 0, 1);
        cyc("R6", 0, 0, 0, 0, 0, 0);
        // R8: pointer write overrides a step in the same cycle
        cyc("R8", 0, 0, 1, 5, 1, 1);
        cyc("R8", 0, 0, 0, 0, 0, 0);
        // R10: both strobes behave as a write (mode 11 post-inc)
        cyc("R10", 1, mk(127, 3), 1, 20, 0, 0);
        cyc("R10", 0, 0, 0, 0, 1, 1);
        cyc("R10", 0, 0, 0, 0, 0, 0);
        // R9: mode write to pointer 1 only; pointer 0 keeps mode 11
        cyc("R9", 2, mk(127, 1), 2, 60, 0, 0);
        cyc("R9", 0, 0, 0, 0, 3, 0);
        cyc("R9", 0, 0, 0, 0, 0, 3);
        // R11: access same cycle as mode write uses old mode
        cyc("R11", 1, mk(127, 0), 0, 0, 1, 0);
        cyc("R11", 0, 0, 0, 0, 1, 0);
        cyc("R11", 0, 0, 0, 0, 0, 0);
        // R7: random mix of everything
        for (int n = 0; n < 400; n++) begin
            int mw = ($urandom % 8 == 0) ? int'($urandom % 4) : 0;
            int msk = ($urandom % 2) ? 127 : (1 << ($urandom % 8)) - 1;
            int pw = ($urandom % 10 == 0) ? int'($urandom % 4) : 0;
            cyc("R7", mw, mk(msk, $urandom % 4), pw, $urandom % 128,
                $urandom % 4, $urandom % 4);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule